// File: doc/BRIEF.md
# Time-Multiplexed Exposure Sequencer

This block schedules the storage-gate drive codes for a pixel array whose pixels hold several charge buckets, either two or four. A single exposure is cut into rounds. Within each round every active bucket gets one transfer slot, in ascending bucket order. During its slot, that bucket's storage gate is driven to the transfer level, so photodiode charge flows into the bucket. All other gates stay at the hold level. Each bucket has its own programmable slot length, so the ratio of lengths sets the exposure ratio between the resulting images. Each image is the sum of all the slots of its bucket.

A one-cycle hold gap separates consecutive transfers, so at most one gate is ever at the transfer level. The photodiode reset gate is held while the sequencer is idle. It is released when the first slot begins and asserted again when the exposure finishes. A light-source enable can be tied to one chosen bucket, and it is then on exactly during that bucket's slots.

The controller is built around four states:
- `ST_IDLE`: waiting for start.
- `ST_XFER`: a bucket is transferring.
- `ST_GAP`: the hold gap between slots.
- `ST_FIN`: the cycle that pulses done.

The transitions are:
- IDLE→XFER on start.
- XFER→XFER while the slot counter runs.
- XFER→GAP at the end of a slot that is not the last one.
- XFER→FIN at the end of the last slot of the last round.
- GAP→XFER always.
- FIN→IDLE always.

Top module: `tmx_seq`

## Requirements
- R1: After reset and whenever idle, every gate code is hold (01), `pd_reset` is 1, `light_on` is 0, `busy` is 0 and `done` is 0.
- R2: A `start` sampled while idle makes bucket 0's gate code transfer (10) and `pd_reset` 0 in the next cycle.
- R3: Each bucket's transfer interval lasts max(L,1) consecutive cycles, where L is its slot length field. Bucket i's field is `slot_len[i*SLOT_W +: SLOT_W]`.
- R4: Buckets are served in the order 0,1 when `quad_mode` is 0, and 0,1,2,3 when it is 1. The order repeats every round. Buckets outside the active set stay at hold.
- R5: At most one gate is at transfer in any cycle. Exactly one all-hold cycle separates the end of one transfer interval from the start of the next.
- R6: The dump code (00) is never driven, and code 11 is never driven.
- R7: The number of rounds is max(`rounds`,1). Each active bucket accumulates rounds×max(L,1) transfer cycles per exposure.
- R8: `done` is a single-cycle pulse in the cycle right after the last transfer cycle. In that cycle all gates are at hold and `pd_reset` is 1. The block is idle in the following cycle.
- R9: `light_on` is 1 exactly in the cycles where `light_sel` is enabled and the selected bucket is at transfer. A selected bucket outside the active set never lights.
- R10: While busy, `start` and changes to any configuration input have no effect on the schedule, because configuration is captured at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an exposure (sampled while idle) |
| quad_mode | input | 1 | 0: two buckets, 1: four buckets |
| slot_len | input | N_BKT*SLOT_W | Per-bucket slot length in cycles, 0 treated as 1 |
| rounds | input | REP_W | Number of rounds, 0 treated as 1 |
| light_sel | input | 1 | Enable light sync |
| light_bkt | input | BK_W | Bucket the light follows |
| sg_lvl | output | 2*N_BKT | Gate codes, bucket i at [2i+1:2i]: 00 dump, 01 hold, 10 transfer |
| pd_reset | output | 1 | Photodiode reset / anti-blooming gate |
| light_on | output | 1 | Light-source enable |
| busy | output | 1 | Exposure in progress |
| done | output | 1 | One-cycle end-of-exposure pulse |

## Verification
The bench builds the block with N_BKT=4, SLOT_W=8 and REP_W=4. Slot lengths stay small, so a full exposure takes tens of cycles. The bench sweeps both bucket modes, three length patterns, zero, one and three rounds, and every light bucket, and predicts every output cycle by cycle. The length patterns include zero lengths, and the light sweep includes buckets outside the active set. A separate run pulses `start` and scrambles the configuration mid-exposure, to show that the captured schedule is kept.

// File: rtl/tmx_pkg.sv
package tmx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_GAP  = 2'd2,
        ST_FIN  = 2'd3
    } tmx_state_e;

    typedef logic [1:0] lvl_t;
    localparam lvl_t LV_DUMP = 2'b00;
    localparam lvl_t LV_HOLD = 2'b01;
    localparam lvl_t LV_XFER = 2'b10;
endpackage

// File: rtl/tmx_fsm.sv
module tmx_fsm
    import tmx_pkg::*;
#(
    parameter int N_BKT  = 4,
    parameter int SLOT_W = 8,
    parameter int REP_W  = 4,
    localparam int BK_W  = (N_BKT > 1) ? $clog2(N_BKT) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    quad_mode,
    input  logic [N_BKT*SLOT_W-1:0] slot_len,
    input  logic [REP_W-1:0]        rounds,
    input  logic                    light_sel,
    input  logic [BK_W-1:0]         light_bkt,
    output tmx_state_e              state,
    output logic [BK_W-1:0]         bkt,
    output logic                    lsel_q,
    output logic [BK_W-1:0]         lbkt_q
);
    tmx_state_e        st_nx;
    logic [SLOT_W-1:0] len_q [N_BKT];
    logic              quad_q;
    logic [SLOT_W-1:0] cnt;
    logic [REP_W-1:0]  rep;
    logic [BK_W-1:0]   last_bkt;
    logic [BK_W-1:0]   next_bkt;
    logic [SLOT_W-1:0] nx_len;

    function automatic logic [SLOT_W-1:0] len_m1(input logic [SLOT_W-1:0] l);
        return (l == '0) ? '0 : l - 1'b1;
    endfunction

    always_comb begin
        if (N_BKT > 2 && quad_q) last_bkt = BK_W'(N_BKT - 1);
        else                     last_bkt = BK_W'(1);
        next_bkt = (bkt == last_bkt) ? '0 : bkt + 1'b1;
        nx_len   = len_q[next_bkt];
    end

    // next-state logic
    always_comb begin
        st_nx = state;
        unique case (state)
            ST_IDLE: if (start) st_nx = ST_XFER;
            ST_XFER: if (cnt == '0) st_nx = (bkt == last_bkt && rep == '0) ? ST_FIN : ST_GAP;
            ST_GAP:  st_nx = ST_XFER;
            ST_FIN:  st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= st_nx;
    end

    // slot, bucket and round bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_BKT; i++) len_q[i] <= '0;
            quad_q <= 1'b0;
            lsel_q <= 1'b0;
            lbkt_q <= '0;
            bkt    <= '0;
            cnt    <= '0;
            rep    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        for (int i = 0; i < N_BKT; i++)
                            len_q[i] <= slot_len[i*SLOT_W +: SLOT_W];
                        quad_q <= quad_mode;
                        lsel_q <= light_sel;
                        lbkt_q <= light_bkt;
                        bkt    <= '0;
                        cnt    <= len_m1(slot_len[SLOT_W-1:0]);
                        rep    <= (rounds == '0) ? '0 : rounds - 1'b1;
                    end
                end
                ST_XFER: begin
                    if (cnt != '0) cnt <= cnt - 1'b1;
                end
                ST_GAP: begin
                    bkt <= next_bkt;
                    cnt <= len_m1(nx_len);
                    if (bkt == last_bkt) rep <= rep - 1'b1;
                end
                ST_FIN: begin
                    bkt <= '0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tmx_gate_drv.sv
module tmx_gate_drv
    import tmx_pkg::*;
#(
    parameter int N_BKT = 4,
    localparam int BK_W = (N_BKT > 1) ? $clog2(N_BKT) : 1
) (
    input  tmx_state_e         state,
    input  logic [BK_W-1:0]    bkt,
    output logic [2*N_BKT-1:0] sg_lvl,
    output logic               pd_reset
);
    for (genvar i = 0; i < N_BKT; i++) begin : g_gate
        always_comb begin
            if (state == ST_XFER && bkt == BK_W'(i)) sg_lvl[2*i +: 2] = LV_XFER;
            else                                    sg_lvl[2*i +: 2] = LV_HOLD;
        end
    end

    always_comb pd_reset = (state == ST_IDLE) || (state == ST_FIN);
endmodule

// File: rtl/tmx_light_sync.sv
module tmx_light_sync
    import tmx_pkg::*;
#(
    parameter int N_BKT = 4,
    localparam int BK_W = (N_BKT > 1) ? $clog2(N_BKT) : 1
) (
    input  tmx_state_e      state,
    input  logic [BK_W-1:0] bkt,
    input  logic            lsel_q,
    input  logic [BK_W-1:0] lbkt_q,
    output logic            light_on
);
    always_comb light_on = lsel_q && (state == ST_XFER) && (bkt == lbkt_q);
endmodule

// File: rtl/tmx_seq.sv
module tmx_seq
    import tmx_pkg::*;
#(
    parameter int N_BKT  = 4,
    parameter int SLOT_W = 8,
    parameter int REP_W  = 4,
    localparam int BK_W  = (N_BKT > 1) ? $clog2(N_BKT) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    quad_mode,
    input  logic [N_BKT*SLOT_W-1:0] slot_len,
    input  logic [REP_W-1:0]        rounds,
    input  logic                    light_sel,
    input  logic [BK_W-1:0]         light_bkt,
    output logic [2*N_BKT-1:0]      sg_lvl,
    output logic                    pd_reset,
    output logic                    light_on,
    output logic                    busy,
    output logic                    done
);
    tmx_state_e      state;
    logic [BK_W-1:0] bkt;
    logic            lsel_q;
    logic [BK_W-1:0] lbkt_q;

    tmx_fsm #(.N_BKT(N_BKT), .SLOT_W(SLOT_W), .REP_W(REP_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .quad_mode(quad_mode),
        .slot_len(slot_len), .rounds(rounds), .light_sel(light_sel),
        .light_bkt(light_bkt), .state(state), .bkt(bkt),
        .lsel_q(lsel_q), .lbkt_q(lbkt_q)
    );

    tmx_gate_drv #(.N_BKT(N_BKT)) u_gate (
        .state(state), .bkt(bkt), .sg_lvl(sg_lvl), .pd_reset(pd_reset)
    );

    tmx_light_sync #(.N_BKT(N_BKT)) u_light (
        .state(state), .bkt(bkt), .lsel_q(lsel_q), .lbkt_q(lbkt_q),
        .light_on(light_on)
    );

    // status outputs
    always_comb begin
        busy = (state != ST_IDLE);
        done = (state == ST_FIN);
    end
endmodule

// File: rtl/tmx_seq_chk.sv
module tmx_seq_chk
    import tmx_pkg::*;
#(
    parameter int N_BKT = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [2*N_BKT-1:0] sg_lvl,
    input logic               pd_reset,
    input logic               light_on,
    input logic               busy,
    input logic               done
);
    logic [N_BKT-1:0] hi;
    logic             bad_code;

    always_comb begin
        bad_code = 1'b0;
        for (int i = 0; i < N_BKT; i++) begin
            hi[i] = (sg_lvl[2*i +: 2] == LV_XFER);
            if (sg_lvl[2*i +: 2] == LV_DUMP || sg_lvl[2*i +: 2] == 2'b11) bad_code = 1'b1;
        end
    end

    a_r1_idle_state: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (pd_reset && hi == '0 && !light_on && !done));

    a_r2_start_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (hi[0] && !pd_reset && busy));

    a_r5_one_high: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(hi) <= 1);

    a_r5_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (hi != '0 && $past(hi) != '0) |-> (hi == $past(hi)));

    a_r6_no_dump: assert property (@(posedge clk) disable iff (!rst_n)
        !bad_code);

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (hi == '0 && pd_reset));

    a_r9_light_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
        light_on |-> (hi != '0 && !pd_reset));
endmodule

bind tmx_seq tmx_seq_chk #(.N_BKT(N_BKT)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .sg_lvl(sg_lvl),
    .pd_reset(pd_reset), .light_on(light_on), .busy(busy), .done(done)
);

// File: tb/test_tmx_seq.sv
`timescale 1ns/1ps
module test_tmx_seq;
    localparam int NB = 4;
    localparam int SW = 8;
    localparam int RW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          quad_mode = 1'b0;
    logic [NB*SW-1:0] slot_len = '0;
    logic [RW-1:0] rounds = '0;
    logic          light_sel = 1'b0;
    logic [1:0]    light_bkt = '0;
    logic [2*NB-1:0] sg_lvl;
    logic          pd_reset, light_on, busy, done;

    int checks = 0;
    int failures = 0;
    int hcnt [NB];

    always #5 clk = ~clk;

    tmx_seq #(.N_BKT(NB), .SLOT_W(SW), .REP_W(RW)) i_tmx_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .quad_mode(quad_mode),
        .slot_len(slot_len), .rounds(rounds), .light_sel(light_sel),
        .light_bkt(light_bkt), .sg_lvl(sg_lvl), .pd_reset(pd_reset),
        .light_on(light_on), .busy(busy), .done(done)
    );

    task automatic cmp(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s: got %0h exp %0h at %0t", req, what, got, exp, $time);
        end
    endtask

    // hb: bucket expected at transfer, -1 for none
    task automatic check_cycle(input int hb, input bit ex_light, input bit ex_ab,
                               input bit ex_done, input bit ex_busy, input string req);
        logic [2*NB-1:0] exp_sg;
        bit bad;
        bad = 0;
        for (int i = 0; i < NB; i++) begin
            exp_sg[2*i +: 2] = (i == hb) ? 2'b10 : 2'b01;
            if (sg_lvl[2*i +: 2] == 2'b10) hcnt[i]++;
            if (sg_lvl[2*i +: 2] == 2'b00 || sg_lvl[2*i +: 2] == 2'b11) bad = 1;
        end
        cmp(req, "sg_lvl", int'(sg_lvl), int'(exp_sg));
        cmp("R6", "bad code", int'(bad), 0);
        cmp("R9", "light_on", int'(light_on), int'(ex_light));
        cmp(req, "pd_reset", int'(pd_reset), int'(ex_ab));
        cmp(req, "done", int'(done), int'(ex_done));
        cmp(req, "busy", int'(busy), int'(ex_busy));
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_exp(input bit quad, input int l0, input int l1, input int l2,
                           input int l3, input int reps, input bit len_en,
                           input int lb, input bit disturb);
        int lv [NB];
        int nb, rr, cyc;
        lv[0] = l0; lv[1] = l1; lv[2] = l2; lv[3] = l3;
        quad_mode = quad;
        for (int i = 0; i < NB; i++) slot_len[i*SW +: SW] = SW'(lv[i]);
        rounds    = RW'(reps);
        light_sel = len_en;
        light_bkt = 2'(lb);
        for (int i = 0; i < NB; i++) hcnt[i] = 0;
        nb = quad ? 4 : 2;
        rr = (reps == 0) ? 1 : reps;
        start = 1'b1;
        step();
        start = 1'b0;
        cyc = 0;
        for (int r = 0; r < rr; r++) begin
            for (int b = 0; b < nb; b++) begin
                int e;
                e = (lv[b] == 0) ? 1 : lv[b];
                for (int k = 0; k < e; k++) begin
                    check_cycle(b, len_en && (lb == b), 1'b0, 1'b0, 1'b1,
                                (r == 0 && b == 0 && k == 0) ? "R2" : "R3/R4");
                    if (disturb && cyc == 2) begin
                        start = 1'b1;
                        quad_mode = ~quad;
                        slot_len = {NB{8'd5}};
                        rounds = 4'd7;
                        light_bkt = 2'(lb + 1);
                        step();
                        start = 1'b0;
                    end else begin
                        step();
                    end
                    cyc++;
                end
                if (!(r == rr - 1 && b == nb - 1)) begin
                    check_cycle(-1, 1'b0, 1'b0, 1'b0, 1'b1, "R5");
                    step();
                    cyc++;
                end
            end
        end
        check_cycle(-1, 1'b0, 1'b1, 1'b1, 1'b1, "R8");
        step();
        check_cycle(-1, 1'b0, 1'b1, 1'b0, 1'b0, disturb ? "R10" : "R8");
        for (int i = 0; i < NB; i++) begin
            int ex;
            ex = (i < nb) ? rr * ((lv[i] == 0) ? 1 : lv[i]) : 0;
            cmp("R7", "transfer cycles per bucket", hcnt[i], ex);
        end
        step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        check_cycle(-1, 1'b0, 1'b1, 1'b0, 1'b0, "R1");
        step();
        rst_n = 1'b1;
        step();
        check_cycle(-1, 1'b0, 1'b1, 1'b0, 1'b0, "R1");
        step();
        check_cycle(-1, 1'b0, 1'b1, 1'b0, 1'b0, "R1");

        for (int q = 0; q < 2; q++) begin
            for (int p = 0; p < 3; p++) begin
                for (int rp = 0; rp < 3; rp++) begin
                    for (int lb = 0; lb < 4; lb++) begin
                        int reps;
                        reps = (rp == 0) ? 0 : ((rp == 1) ? 1 : 3);
                        case (p)
                            0: run_exp(q[0], 8, 4, 2, 1, reps, 1'b1, lb, 1'b0);
                            1: run_exp(q[0], 0, 3, 1, 2, reps, 1'b1, lb, 1'b0);
                            default: run_exp(q[0], 1, 1, 1, 1, reps, 1'b1, lb, 1'b0);
                        endcase
                    end
                end
            end
        end
        run_exp(1'b1, 3, 2, 4, 1, 2, 1'b0, 2, 1'b0);
        run_exp(1'b1, 2, 2, 2, 2, 2, 1'b1, 1, 1'b1);
        run_exp(1'b0, 3, 1, 0, 0, 3, 1'b1, 0, 1'b1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule